// File: doc/BRIEF.md
# Paged Work-RAM and ROM Bank Decoder

This block sits beside an 8-bit CPU and serves three functions. It decodes the CPU address into one-hot chip selects for the fixed regions around it. It holds a write-only control byte. It owns an 8 KiB single-port work RAM, which the CPU sees through a 6 KiB window.

The control byte sets three things: the 8 KiB ROM page presented in the banked ROM window, which half of the RAM's lower 4 KiB appears in the 2 KiB paged part of the window, and two coin-counter outputs. The upper 4 KiB of the window always maps one-to-one onto the top 4 KiB of the RAM.

RAM reads are registered. Any cycle whose address lies outside the work-RAM window yields 0xFF on the read port one cycle later. The control byte is loaded through its own write strobe. Decoding the latch's own address is left to the surrounding logic.

Top module: `banked_map_decoder`

## Requirements
- R1: On a rising clock edge with `ctl_we` high, the control byte loads `cpu_wdata`. Reset clears it to 0x00, which selects RAM page 0 and ROM page 0 with both coin outputs low. Without `ctl_we` the control byte holds its value.
- R2: CPU addresses 0x0800–0x0FFF reach RAM offsets 0x000–0x7FF when control bit 5 is 0, and RAM offsets 0x800–0xFFF when control bit 5 is 1. Both use the low 11 address bits as the offset.
- R3: CPU addresses 0x1000–0x1FFF reach RAM offset equal to the address (0x1000–0x1FFF), whatever the state of control bit 5.
- R4: `rom_addr` equals 0x10000 + page × 0x2000 + (cpu_addr & 0x1FFF), where page is control bits 4:0. Pages 16–31 are passed through unchanged.
- R5: `coin0` follows control bit 6 and `coin1` follows control bit 7.
- R6: `cs_pal` is high for 0x0600–0x06FF, `cs_pf0` for 0x2000–0x2FFF, `cs_spr` for 0x3000–0x3FFF, `cs_pf1` for 0x4000–0x4FFF and `cs_rom` for 0x6000–0x7FFF. At most one is high at a time, and none is high for 0x0700–0x07FF or any other address.
- R7: `cpu_rdata` in a cycle shows the RAM byte addressed in the previous cycle. When that previous cycle also wrote the same byte, `cpu_rdata` shows the byte's old value.
- R8: A cycle whose address is outside 0x0800–0x1FFF gives `cpu_rdata` = 0xFF in the next cycle. A write in such a cycle leaves the RAM unchanged.
- R9: The RAM is written only in a cycle where `cpu_we` is high and the address lies in 0x0800–0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data, also the control byte source |
| cpu_we | input | 1 | CPU memory write enable |
| ctl_we | input | 1 | Control byte load strobe |
| cpu_rdata | output | 8 | Registered work-RAM read data, 0xFF outside the window |
| rom_addr | output | 19 | Banked ROM byte address |
| cs_pal | output | 1 | Palette RAM select |
| cs_pf0 | output | 1 | Playfield 0 video RAM select |
| cs_spr | output | 1 | Sprite RAM select |
| cs_pf1 | output | 1 | Playfield 1 video RAM select |
| cs_rom | output | 1 | Banked ROM window select |
| coin0 | output | 1 | Coin counter 0 drive |
| coin1 | output | 1 | Coin counter 1 drive |

## Verification
The hardest case to reach is RAM offsets 0x800–0xFFF. They are reachable only while control bit 5 is set, so a fault that drops or inverts the page bit appears only when the same window address holds distinct bytes under the two pages. The stimulus writes different values to one window address under each page. It then writes the same low offset through the direct range, flips the page back and forth, and reads all three. Any aliasing between the pages, or between a page and the direct range, shows up as a wrong byte.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_PAL,
    RG_WRAM,
    RG_PF0,
    RG_SPR,
    RG_PF1,
    RG_ROMWIN
  } region_e;

  localparam logic [15:0] PAL_LO   = 16'h0600;
  localparam logic [15:0] PAL_HI   = 16'h06FF;
  localparam logic [15:0] WRAM_LO  = 16'h0800;
  localparam logic [15:0] WRAM_HI  = 16'h1FFF;
  localparam logic [15:0] PF0_LO   = 16'h2000;
  localparam logic [15:0] PF0_HI   = 16'h2FFF;
  localparam logic [15:0] SPR_LO   = 16'h3000;
  localparam logic [15:0] SPR_HI   = 16'h3FFF;
  localparam logic [15:0] PF1_LO   = 16'h4000;
  localparam logic [15:0] PF1_HI   = 16'h4FFF;
  localparam logic [15:0] ROMW_LO  = 16'h6000;
  localparam logic [15:0] ROMW_HI  = 16'h7FFF;
  localparam logic [15:0] PAGED_HI = 16'h0FFF;
endpackage

// File: rtl/ctl_latch.sv
module ctl_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/map_decode.sv
module map_decode
  import wram_map_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int RAM_AW      = 13,
  parameter int BANK_W      = 5,
  parameter int ROM_PAGE_AW = 13,
  parameter int ROM_BASE_PG = 8,
  localparam int WIN_OW     = RAM_AW - 2,
  localparam int ROM_AW     = BANK_W + 1 + ROM_PAGE_AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_sel,
  input  logic [BANK_W-1:0] bank,
  output region_e           region,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [BANK_W:0] rom_pg;

  always_comb begin
    region = RG_NONE;
    if      (addr >= PAL_LO  && addr <= PAL_HI ) region = RG_PAL;
    else if (addr >= WRAM_LO && addr <= WRAM_HI) region = RG_WRAM;
    else if (addr >= PF0_LO  && addr <= PF0_HI ) region = RG_PF0;
    else if (addr >= SPR_LO  && addr <= SPR_HI ) region = RG_SPR;
    else if (addr >= PF1_LO  && addr <= PF1_HI ) region = RG_PF1;
    else if (addr >= ROMW_LO && addr <= ROMW_HI) region = RG_ROMWIN;
  end

  always_comb begin
    if (addr <= PAGED_HI)
      ram_addr = {1'b0, page_sel, addr[WIN_OW-1:0]};
    else
      ram_addr = addr[RAM_AW-1:0];
  end

  assign rom_pg   = {1'b0, bank} + (BANK_W+1)'(ROM_BASE_PG);
  assign rom_addr = {rom_pg, addr[ROM_PAGE_AW-1:0]};
endmodule

// File: rtl/work_ram.sv
module work_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 13,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      if (we) mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/banked_map_decoder.sv
module banked_map_decoder
  import wram_map_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int RAM_AW      = 13,
  parameter int BANK_W      = 5,
  parameter int PAGE_BIT    = 5,
  parameter int COIN0_BIT   = 6,
  parameter int COIN1_BIT   = 7,
  parameter int ROM_PAGE_AW = 13,
  parameter int ROM_BASE_PG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  input  logic                          cpu_we,
  input  logic                          ctl_we,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic [BANK_W+ROM_PAGE_AW:0]   rom_addr,
  output logic                          cs_pal,
  output logic                          cs_pf0,
  output logic                          cs_spr,
  output logic                          cs_pf1,
  output logic                          cs_rom,
  output logic                          coin0,
  output logic                          coin1
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic [DATA_W-1:0] ctl;
  region_e           region;
  region_e           region_q;
  region_e           region_nxt;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_q;
  logic              ram_en;
  logic              ram_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  ctl_latch #(.DATA_W(DATA_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_q),
    .load  (ctl_we),
    .d     (cpu_wdata),
    .q     (ctl)
  );

  map_decode #(
    .ADDR_W      (ADDR_W),
    .RAM_AW      (RAM_AW),
    .BANK_W      (BANK_W),
    .ROM_PAGE_AW (ROM_PAGE_AW),
    .ROM_BASE_PG (ROM_BASE_PG)
  ) u_dec (
    .addr     (cpu_addr),
    .page_sel (ctl[PAGE_BIT]),
    .bank     (ctl[BANK_W-1:0]),
    .region   (region),
    .ram_addr (ram_addr),
    .rom_addr (rom_addr)
  );

  assign ram_en = (region == RG_WRAM);
  assign ram_we = ram_en && cpu_we;

  work_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (cpu_wdata),
    .rdata (ram_q)
  );

  always_comb region_nxt = region;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) region_q <= RG_NONE;
    else        region_q <= region_nxt;
  end

  assign cpu_rdata = (region_q == RG_WRAM) ? ram_q : '1;

  assign cs_pal = (region == RG_PAL);
  assign cs_pf0 = (region == RG_PF0);
  assign cs_spr = (region == RG_SPR);
  assign cs_pf1 = (region == RG_PF1);
  assign cs_rom = (region == RG_ROMWIN);
  assign coin0  = ctl[COIN0_BIT];
  assign coin1  = ctl[COIN1_BIT];
endmodule

// File: rtl/banked_map_checker.sv
module banked_map_checker #(
  parameter int BANK_W      = 5,
  parameter int ROM_PAGE_AW = 13
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [15:0]                 cpu_addr,
  input logic [7:0]                  cpu_wdata,
  input logic                        ctl_we,
  input logic [7:0]                  cpu_rdata,
  input logic [BANK_W+ROM_PAGE_AW:0] rom_addr,
  input logic [4:0]                  cs_vec,
  input logic                        coin0,
  input logic                        coin1
);
  localparam int PG_W = BANK_W + 1;

  a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_vec));

  a_r6_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:8] == 8'h07) |-> (cs_vec == 5'd0));

  a_r8_ff_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h0800 || cpu_addr > 16'h1FFF) |=> (cpu_rdata == 8'hFF));

  a_r5_coin_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ({coin1, coin0} == $past(cpu_wdata[7:6])));

  a_r1_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable({coin1, coin0}) && $stable(rom_addr[BANK_W+ROM_PAGE_AW:ROM_PAGE_AW])));

  a_r4_rom_page: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (rom_addr[BANK_W+ROM_PAGE_AW:ROM_PAGE_AW] ==
                ({1'b0, $past(cpu_wdata[BANK_W-1:0])} + PG_W'(8))));
endmodule

bind banked_map_decoder banked_map_checker #(
  .BANK_W      (BANK_W),
  .ROM_PAGE_AW (ROM_PAGE_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .ctl_we    (ctl_we),
  .cpu_rdata (cpu_rdata),
  .rom_addr  (rom_addr),
  .cs_vec    ({cs_rom, cs_pf1, cs_spr, cs_pf0, cs_pal}),
  .coin0     (coin0),
  .coin1     (coin1)
);

// File: tb/banked_map_decoder_bench.sv
module banked_map_decoder_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 16;
  localparam logic [7:0] TBL_CTL = 8'h13;

  // {address, expected selects as {rom, pf1, spr, pf0, pal}}
  localparam logic [20:0] DEC_TBL [NVEC] = '{
    {16'h0600, 5'b00001}, {16'h06FF, 5'b00001},
    {16'h0700, 5'b00000}, {16'h07FF, 5'b00000},
    {16'h0800, 5'b00000}, {16'h1FFF, 5'b00000},
    {16'h2000, 5'b00010}, {16'h2FFF, 5'b00010},
    {16'h3000, 5'b00100}, {16'h3ABC, 5'b00100},
    {16'h4000, 5'b01000}, {16'h4FFF, 5'b01000},
    {16'h5000, 5'b00000}, {16'h6000, 5'b10000},
    {16'h7FFF, 5'b10000}, {16'h8000, 5'b00000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic        ctl_we;
  logic [7:0]  cpu_rdata;
  logic [18:0] rom_addr;
  logic        cs_pal, cs_pf0, cs_spr, cs_pf1, cs_rom, coin0, coin1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_map_decoder u_banked_map_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ctl_we(ctl_we), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
    .cs_pal(cs_pal), .cs_pf0(cs_pf0), .cs_spr(cs_spr), .cs_pf1(cs_pf1),
    .cs_rom(cs_rom), .coin0(coin0), .coin1(coin1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk);
    cpu_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  function automatic logic [18:0] rom_exp(input logic [4:0] pg, input logic [15:0] a);
    return 19'h10000 + 19'(pg) * 19'h2000 + 19'(a & 16'h1FFF);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; cpu_addr = 16'h6000; cpu_wdata = 8'h00; cpu_we = 1'b0; ctl_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state: page 0, coins low, registered read idle at 0xFF
    check("R1 reset coins", {30'd0, coin1, coin0}, 32'd0);
    check("R1 reset rom page", 32'(rom_addr), 32'h10000);
    check("R8 reset rdata", 32'(cpu_rdata), 32'hFF);

    // R6/R4 table walk
    set_ctl(TBL_CTL);
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cpu_addr = DEC_TBL[i][20:5];
      #1;
      check("R6 selects", 32'({cs_rom, cs_pf1, cs_spr, cs_pf0, cs_pal}), 32'(DEC_TBL[i][4:0]));
      if (DEC_TBL[i][4])
        check("R4 rom addr", 32'(rom_addr), 32'(rom_exp(TBL_CTL[4:0], DEC_TBL[i][20:5])));
    end

    // R4 upper pages passed through
    set_ctl(8'h1F);
    @(negedge clk); cpu_addr = 16'h7FFF; #1;
    check("R4 page 31", 32'(rom_addr), 32'h4FFFF);
    set_ctl(8'h10);
    @(negedge clk); cpu_addr = 16'h6000; #1;
    check("R4 page 16", 32'(rom_addr), 32'h30000);

    // R5 coin outputs
    set_ctl(8'h40); check("R5 coin bit6", {30'd0, coin1, coin0}, 32'b01);
    set_ctl(8'h80); check("R5 coin bit7", {30'd0, coin1, coin0}, 32'b10);
    set_ctl(8'hC0); check("R5 both coins", {30'd0, coin1, coin0}, 32'b11);

    // R2/R3 paging and aliasing
    set_ctl(8'h00);
    mem_wr(16'h0923, 8'hA1);
    set_ctl(8'h20);
    mem_wr(16'h0923, 8'hB2);
    mem_wr(16'h1123, 8'hC3);
    mem_wr(16'h1923, 8'hD4);
    mem_rd(16'h0923, rd); check("R2 page1 read", 32'(rd), 32'hB2);
    mem_rd(16'h1123, rd); check("R3 direct page1", 32'(rd), 32'hC3);
    set_ctl(8'h00);
    mem_rd(16'h0923, rd); check("R2 page0 read", 32'(rd), 32'hA1);
    mem_rd(16'h1123, rd); check("R3 direct page0", 32'(rd), 32'hC3);
    mem_rd(16'h1923, rd); check("R3 direct high", 32'(rd), 32'hD4);

    // R9 no write without cpu_we
    @(negedge clk); cpu_addr = 16'h1123; cpu_wdata = 8'h77; cpu_we = 1'b0;
    mem_rd(16'h1123, rd); check("R9 we low ignored", 32'(rd), 32'hC3);

    // R7 read-old on same-cycle write, then new value
    @(negedge clk); cpu_addr = 16'h1123; cpu_wdata = 8'h99; cpu_we = 1'b1;
    @(negedge clk); cpu_we = 1'b0;
    check("R7 old data on write", 32'(cpu_rdata), 32'hC3);
    mem_rd(16'h1123, rd); check("R7 new data", 32'(rd), 32'h99);

    // R8 outside window reads 0xFF, writes ignored
    mem_rd(16'h0700, rd); check("R8 hole reads FF", 32'(rd), 32'hFF);
    mem_rd(16'h2123, rd); check("R8 pf0 reads FF", 32'(rd), 32'hFF);
    mem_wr(16'h0123, 8'h5A);
    mem_wr(16'h2923, 8'h5B);
    mem_rd(16'h0923, rd); check("R8 write outside ignored", 32'(rd), 32'hA1);

    // R1 hold: no strobe keeps page 0 selected
    @(negedge clk); cpu_wdata = 8'h20; ctl_we = 1'b0;
    mem_rd(16'h0923, rd); check("R1 hold page", 32'(rd), 32'hA1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule